// File: doc/BRIEF.md
# CCD Sampling Strobe Generator

This block derives every per-pixel sampling strobe of a three-channel image-sensor front end from a single master clock and a one-clock pixel sync pulse. Each pixel is timed by a phase counter that the sync pulse clears. From that count the block produces a video-sample strobe, a reset-sample strobe, an optional clamp strobe and a converter-sample enable. With the enable it gives a channel code for the converter input multiplexer and a flag that marks whether the word in that slot is worth keeping.

Configuration inputs choose one of six operating modes. Each mode fixes a clock-to-sync ratio of 6, 3, 2 or 8 and selects colour or mono operation. Further inputs select correlated double sampling or single-ended sampling, move the reset-sample position, and pick the mono channel. The configuration is expected to be static while a pixel is being timed. The clamp request pin is sampled together with the sync pulse, and it arms a clamp for that pixel only.

Control is a two-state machine. In `ST_IDLE` no pixel is being timed and every output is quiet. In `ST_RUN` the phase counter is stepping through a pixel. The transitions are:
- start: `ST_IDLE` to `ST_RUN` when sync is seen;
- restart: `ST_RUN` to `ST_RUN` at phase 0 when sync is seen;
- advance: `ST_RUN` to `ST_RUN` at phase+1;
- expire: `ST_RUN` to `ST_IDLE` after the last phase of the period when no sync is seen.

Top module: `ccd_sample_timer`

## Requirements
- R1: After reset the block is in the idle state. Until the first sync pulse, rs_stb, vs_stb, cl_stb, adc_en and slot_valid are low and adc_chan is 00.
- R2: The cycle after an edge that samples sync_in high is phase 0, and vs_stb is high only in phase 0. The period in clocks follows cfg_mode: 0 colour 6, 1 mono 6, 2 fast mono 3, 3 max-speed mono 2, 4 slow colour 8, 5 slow mono 8. Codes 6 and 7 behave as code 0. If no new sync arrives, the block is idle once the period has elapsed.
- R3: With correlated double sampling active, rs_stb is high in phase 2, 3, 4 or 5 for cfg_rst_adj 00, 01, 10 or 11 respectively.
- R4: When cfg_cds is 0, or in max-speed mono mode whatever cfg_cds is, rs_stb is high in phase 0 together with vs_stb.
- R5: In fast mono mode with double sampling active, rs_stb is high in phase 2 whatever cfg_rst_adj holds.
- R6: cl_stb is high in exactly the cycle of rs_stb, and only for a pixel whose sync edge also sampled clamp_req high. A request sampled on any other edge has no effect.
- R7: adc_en is high in the even phases of a pixel for periods 2, 6 and 8, and only in phase 0 for period 3.
- R8: adc_chan follows slot = phase/2. In colour modes slot 0 gives 00 (red), slot 1 gives 01 (green), slot 2 gives 10 (blue) and slot 3 gives 00. In mono modes adc_chan equals cfg_mono_chan, with code 11 taken as 00.
- R9: slot_valid is high only together with adc_en. In colour modes it marks slots 0 to 2. In mono modes it marks slot 0 only.
- R10: A sync pulse during a pixel restarts the count at phase 0 on the next cycle. A sync in the last phase gives back-to-back pixels with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | master clock, rising edge |
| rst_n | input | 1 | asynchronous reset, active low |
| sync_in | input | 1 | pixel sync pulse, one clock wide |
| clamp_req | input | 1 | clamp request, sampled with sync |
| cfg_mode | input | 3 | operating mode code |
| cfg_cds | input | 1 | 1 = correlated double sampling |
| cfg_rst_adj | input | 2 | reset-sample position adjust |
| cfg_mono_chan | input | 2 | mono channel select |
| rs_stb | output | 1 | reset-sample strobe |
| vs_stb | output | 1 | video-sample strobe |
| cl_stb | output | 1 | clamp strobe |
| adc_en | output | 1 | converter-sample enable |
| adc_chan | output | 2 | converter input multiplexer code |
| slot_valid | output | 1 | word in this slot is valid |

## Verification
The assertions check, on every cycle, the rules that hold in any mode:
- quiet outputs while idle;
- restart to phase 0 after sync, and single-step advance otherwise;
- clamp only together with the reset sample;
- reset sample coinciding with the video sample in single-ended operation;
- no two converter enables in adjacent cycles without a sync;
- the valid flag only inside an enabled slot.

Only the bench's scenarios can show that each mode, adjust code and channel code puts the strobes in the right phase. The same holds for the loss of a clamp request that was not sampled with sync, and for the exact placement of a restarted pixel.

// File: rtl/cst_pkg.sv
package cst_pkg;
    localparam int MAX_PERIOD = 8;
    localparam int PHASE_W    = $clog2(MAX_PERIOD);
    localparam int CHAN_W     = 2;
    localparam int PER_STD    = 6;
    localparam int PER_FAST   = 3;
    localparam int PER_MAX    = 2;
    localparam int PER_SLOW   = 8;
    localparam int RS_EARLY   = 2;

    typedef enum logic [2:0] {
        MODE_COLOUR      = 3'd0,
        MODE_MONO        = 3'd1,
        MODE_FAST_MONO   = 3'd2,
        MODE_MAX_MONO    = 3'd3,
        MODE_SLOW_COLOUR = 3'd4,
        MODE_SLOW_MONO   = 3'd5
    } mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } state_e;
endpackage

// File: rtl/cst_mode_decode.sv
module cst_mode_decode
    import cst_pkg::*;
#(
    parameter int PW = cst_pkg::PHASE_W
) (
    input  logic [2:0]    cfg_mode,
    input  logic          cfg_cds,
    input  logic [1:0]    cfg_rst_adj,
    output logic [PW-1:0] last_phase,
    output logic [PW-1:0] rs_phase,
    output logic          colour,
    output logic          fast3
);
    logic cds_ok;

    always_comb begin
        last_phase = PW'(PER_STD - 1);
        colour     = 1'b1;
        fast3      = 1'b0;
        cds_ok     = 1'b1;
        unique case (mode_e'(cfg_mode))
            MODE_COLOUR: begin
                last_phase = PW'(PER_STD - 1);
            end
            MODE_MONO: begin
                last_phase = PW'(PER_STD - 1);
                colour     = 1'b0;
            end
            MODE_FAST_MONO: begin
                last_phase = PW'(PER_FAST - 1);
                colour     = 1'b0;
                fast3      = 1'b1;
            end
            MODE_MAX_MONO: begin
                last_phase = PW'(PER_MAX - 1);
                colour     = 1'b0;
                cds_ok     = 1'b0;
            end
            MODE_SLOW_COLOUR: begin
                last_phase = PW'(PER_SLOW - 1);
            end
            MODE_SLOW_MONO: begin
                last_phase = PW'(PER_SLOW - 1);
                colour     = 1'b0;
            end
            default: begin
                last_phase = PW'(PER_STD - 1);
            end
        endcase
    end

    always_comb begin
        if (!(cfg_cds && cds_ok))
            rs_phase = '0;
        else if (fast3)
            rs_phase = PW'(RS_EARLY);
        else
            rs_phase = PW'(RS_EARLY) + PW'(cfg_rst_adj);
    end
endmodule

// File: rtl/cst_phase_fsm.sv
module cst_phase_fsm
    import cst_pkg::*;
#(
    parameter int PW = cst_pkg::PHASE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync_in,
    input  logic          clamp_req,
    input  logic [PW-1:0] last_phase,
    output logic          run,
    output logic [PW-1:0] phase,
    output logic          clamp_pend
);
    state_e        state_q, state_d;
    logic [PW-1:0] phase_q, phase_d;
    logic          pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            phase_q <= '0;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            phase_q <= phase_d;
            if (sync_in)
                pend_q <= clamp_req;
        end
    end

    always_comb begin
        state_d = state_q;
        phase_d = phase_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sync_in) begin
                    state_d = ST_RUN;
                    phase_d = '0;
                end
            end
            ST_RUN: begin
                if (sync_in) begin
                    phase_d = '0;
                end else if (phase_q >= last_phase) begin
                    state_d = ST_IDLE;
                    phase_d = '0;
                end else begin
                    phase_d = phase_q + PW'(1);
                end
            end
            default: begin
                state_d = ST_IDLE;
                phase_d = '0;
            end
        endcase
    end

    assign run        = (state_q == ST_RUN);
    assign phase      = phase_q;
    assign clamp_pend = pend_q;

    a_r2_sync_restart: assert property (@(posedge clk) disable iff (!rst_n)
        sync_in |=> (run && phase == '0));

    a_r10_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !sync_in && phase < last_phase) |=> (run && phase == $past(phase) + PW'(1)));
endmodule

// File: rtl/cst_strobe_gen.sv
module cst_strobe_gen
    import cst_pkg::*;
#(
    parameter int PW = cst_pkg::PHASE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [PW-1:0]     phase,
    input  logic [PW-1:0]     rs_phase,
    input  logic              colour,
    input  logic              fast3,
    input  logic              clamp_pend,
    input  logic [CHAN_W-1:0] mono_chan,
    output logic              rs_stb,
    output logic              vs_stb,
    output logic              cl_stb,
    output logic              adc_en,
    output logic [CHAN_W-1:0] adc_chan,
    output logic              slot_valid
);
    localparam int SLOT_W = PW - 1;
    localparam logic [SLOT_W-1:0] SLOT_SPARE = SLOT_W'(3);

    logic [SLOT_W-1:0] slot;

    assign slot = phase[PW-1:1];

    always_comb begin
        vs_stb     = run && (phase == '0);
        rs_stb     = run && (phase == rs_phase);
        cl_stb     = rs_stb && clamp_pend;
        adc_en     = run && (fast3 ? (phase == '0) : !phase[0]);
        adc_chan   = '0;
        slot_valid = 1'b0;
        if (run) begin
            if (colour) begin
                adc_chan   = (slot == SLOT_SPARE) ? '0 : CHAN_W'(slot);
                slot_valid = adc_en && (slot != SLOT_SPARE);
            end else begin
                adc_chan   = (mono_chan == '1) ? '0 : mono_chan;
                slot_valid = adc_en && (slot == '0);
            end
        end
    end

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !(rs_stb || vs_stb || cl_stb || adc_en || slot_valid));

    a_r6_clamp_locked: assert property (@(posedge clk) disable iff (!rst_n)
        cl_stb |-> rs_stb);

    a_r4_single_ended: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_stb && rs_phase == '0) |-> vs_stb);

    a_r9_valid_needs_adc: assert property (@(posedge clk) disable iff (!rst_n)
        slot_valid |-> adc_en);
endmodule

// File: rtl/ccd_sample_timer.sv
module ccd_sample_timer
    import cst_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_in,
    input  logic       clamp_req,
    input  logic [2:0] cfg_mode,
    input  logic       cfg_cds,
    input  logic [1:0] cfg_rst_adj,
    input  logic [1:0] cfg_mono_chan,
    output logic       rs_stb,
    output logic       vs_stb,
    output logic       cl_stb,
    output logic       adc_en,
    output logic [1:0] adc_chan,
    output logic       slot_valid
);
    localparam int PW = cst_pkg::PHASE_W;

    logic [PW-1:0] last_phase;
    logic [PW-1:0] rs_phase;
    logic [PW-1:0] phase;
    logic          colour;
    logic          fast3;
    logic          run;
    logic          clamp_pend;

    cst_mode_decode #(.PW(PW)) u_decode (
        .cfg_mode    (cfg_mode),
        .cfg_cds     (cfg_cds),
        .cfg_rst_adj (cfg_rst_adj),
        .last_phase  (last_phase),
        .rs_phase    (rs_phase),
        .colour      (colour),
        .fast3       (fast3)
    );

    cst_phase_fsm #(.PW(PW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_in    (sync_in),
        .clamp_req  (clamp_req),
        .last_phase (last_phase),
        .run        (run),
        .phase      (phase),
        .clamp_pend (clamp_pend)
    );

    cst_strobe_gen #(.PW(PW)) u_strobe (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .phase      (phase),
        .rs_phase   (rs_phase),
        .colour     (colour),
        .fast3      (fast3),
        .clamp_pend (clamp_pend),
        .mono_chan  (cfg_mono_chan),
        .rs_stb     (rs_stb),
        .vs_stb     (vs_stb),
        .cl_stb     (cl_stb),
        .adc_en     (adc_en),
        .adc_chan   (adc_chan),
        .slot_valid (slot_valid)
    );

    a_r7_adc_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_en && !sync_in) |=> !adc_en);
endmodule

// File: tb/tb_ccd_sample_timer.sv
module tb_ccd_sample_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_in = 1'b0;
    logic       clamp_req = 1'b0;
    logic [2:0] cfg_mode = 3'd0;
    logic       cfg_cds = 1'b1;
    logic [1:0] cfg_rst_adj = 2'b01;
    logic [1:0] cfg_mono_chan = 2'b00;
    logic       rs_stb, vs_stb, cl_stb, adc_en, slot_valid;
    logic [1:0] adc_chan;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    ccd_sample_timer dut (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .clamp_req(clamp_req),
        .cfg_mode(cfg_mode), .cfg_cds(cfg_cds), .cfg_rst_adj(cfg_rst_adj),
        .cfg_mono_chan(cfg_mono_chan), .rs_stb(rs_stb), .vs_stb(vs_stb),
        .cl_stb(cl_stb), .adc_en(adc_en), .adc_chan(adc_chan),
        .slot_valid(slot_valid)
    );

    logic [7:0]  m_rs, m_vs, m_cl, m_adc, m_val;
    logic [15:0] m_ch;

    task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [2:0] md, input logic cds, input logic [1:0] adj,
                           input logic [1:0] ch);
        @(negedge clk);
        cfg_mode = md; cfg_cds = cds; cfg_rst_adj = adj; cfg_mono_chan = ch;
        repeat (9) @(negedge clk);
    endtask

    task automatic start_pixel(input logic req);
        @(negedge clk);
        sync_in = 1'b1; clamp_req = req;
        @(negedge clk);
        sync_in = 1'b0; clamp_req = 1'b0;
    endtask

    // samples eight cycles, the first being the current one
    task automatic capture();
        m_rs = '0; m_vs = '0; m_cl = '0; m_adc = '0; m_val = '0; m_ch = '0;
        for (int i = 0; i < 8; i++) begin
            if (i > 0) @(negedge clk);
            m_rs[i] = rs_stb; m_vs[i] = vs_stb; m_cl[i] = cl_stb;
            m_adc[i] = adc_en; m_val[i] = slot_valid;
            m_ch[2*i +: 2] = adc_chan;
        end
    endtask

    task automatic cmp(input string tag, input logic [7:0] e_rs, input logic [7:0] e_cl,
                       input logic [7:0] e_adc, input logic [7:0] e_val, input logic [15:0] e_ch);
        chk({tag, " R2 vs"}, {8'h0, m_vs}, 16'h0001);
        chk({tag, " R3 rs"}, {8'h0, m_rs}, {8'h0, e_rs});
        chk({tag, " R6 cl"}, {8'h0, m_cl}, {8'h0, e_cl});
        chk({tag, " R7 adc"}, {8'h0, m_adc}, {8'h0, e_adc});
        chk({tag, " R9 valid"}, {8'h0, m_val}, {8'h0, e_val});
        chk({tag, " R8 chan"}, m_ch, e_ch);
    endtask

    task automatic pixel(input string tag, input logic req, input logic [7:0] e_rs,
                         input logic [7:0] e_cl, input logic [7:0] e_adc,
                         input logic [7:0] e_val, input logic [15:0] e_ch);
        start_pixel(req);
        capture();
        cmp(tag, e_rs, e_cl, e_adc, e_val, e_ch);
    endtask

    task automatic t_reset();
        chk("R1 idle strobes", {11'h0, rs_stb, vs_stb, cl_stb, adc_en, slot_valid}, 16'h0);
        chk("R1 idle chan", {14'h0, adc_chan}, 16'h0);
    endtask

    task automatic t_colour_default();
        set_cfg(3'd0, 1'b1, 2'b01, 2'b00);
        pixel("R2 colour clamp", 1'b1, 8'h08, 8'h08, 8'h15, 8'h15, 16'h0A50);
        pixel("R6 colour noclamp", 1'b0, 8'h08, 8'h00, 8'h15, 8'h15, 16'h0A50);
    endtask

    task automatic t_rs_adjust();
        set_cfg(3'd0, 1'b1, 2'b00, 2'b00);
        pixel("R3 adj00", 1'b1, 8'h04, 8'h04, 8'h15, 8'h15, 16'h0A50);
        set_cfg(3'd0, 1'b1, 2'b10, 2'b00);
        pixel("R3 adj10", 1'b1, 8'h10, 8'h10, 8'h15, 8'h15, 16'h0A50);
        set_cfg(3'd0, 1'b1, 2'b11, 2'b00);
        pixel("R3 adj11", 1'b1, 8'h20, 8'h20, 8'h15, 8'h15, 16'h0A50);
    endtask

    task automatic t_single_ended();
        set_cfg(3'd0, 1'b0, 2'b11, 2'b00);
        pixel("R4 single ended", 1'b1, 8'h01, 8'h01, 8'h15, 8'h15, 16'h0A50);
    endtask

    task automatic t_fast_mono();
        set_cfg(3'd2, 1'b1, 2'b01, 2'b01);
        pixel("R5 fast mono", 1'b1, 8'h04, 8'h04, 8'h01, 8'h01, 16'h0015);
    endtask

    task automatic t_max_mono();
        set_cfg(3'd3, 1'b1, 2'b11, 2'b10);
        pixel("R4 max mono", 1'b0, 8'h01, 8'h00, 8'h01, 8'h01, 16'h000A);
    endtask

    task automatic t_mono_chan();
        set_cfg(3'd1, 1'b1, 2'b01, 2'b01);
        pixel("R8 mono green", 1'b0, 8'h08, 8'h00, 8'h15, 8'h01, 16'h0555);
        set_cfg(3'd1, 1'b1, 2'b01, 2'b11);
        pixel("R8 mono code11", 1'b0, 8'h08, 8'h00, 8'h15, 8'h01, 16'h0000);
    endtask

    task automatic t_slow_modes();
        set_cfg(3'd4, 1'b1, 2'b10, 2'b00);
        pixel("R9 slow colour", 1'b1, 8'h10, 8'h10, 8'h55, 8'h15, 16'h0A50);
        set_cfg(3'd5, 1'b1, 2'b10, 2'b10);
        pixel("R9 slow mono", 1'b0, 8'h10, 8'h00, 8'h55, 8'h01, 16'hAAAA);
    endtask

    task automatic t_reserved_mode();
        set_cfg(3'd7, 1'b1, 2'b01, 2'b10);
        pixel("R2 reserved mode", 1'b0, 8'h08, 8'h00, 8'h15, 8'h15, 16'h0A50);
    endtask

    task automatic t_clamp_ignore();
        set_cfg(3'd0, 1'b1, 2'b01, 2'b00);
        @(negedge clk);
        clamp_req = 1'b1;
        repeat (3) @(negedge clk);
        clamp_req = 1'b0;
        pixel("R6 stray request", 1'b0, 8'h08, 8'h00, 8'h15, 8'h15, 16'h0A50);
    endtask

    task automatic t_resync(input int k, input string tag);
        set_cfg(3'd0, 1'b1, 2'b01, 2'b00);
        start_pixel(1'b0);
        repeat (k) @(negedge clk);
        sync_in = 1'b1;
        @(negedge clk);
        sync_in = 1'b0;
        capture();
        cmp(tag, 8'h08, 8'h00, 8'h15, 8'h15, 16'h0A50);
    endtask

    initial begin
        #(4 * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_colour_default();
        t_rs_adjust();
        t_single_ended();
        t_fast_mono();
        t_max_mono();
        t_mono_chan();
        t_slow_modes();
        t_reserved_mode();
        t_clamp_ignore();
        t_resync(2, "R10 early sync");
        t_resync(5, "R10 back to back");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule